// File: doc/BRIEF.md
# Redundant Store Commit Comparator

This block guards the write path out of a pair of threads that execute the same program redundantly. Every store that the leading thread retires is parked in a buffer as an address and data pair. The store goes out to memory only once the trailing thread has retired its own copy of the same store and both copies agree in address and in data. Until then nothing from the pair reaches memory.

Stores are paired strictly in program order. Each trailing store is compared with the oldest buffered leading store that has not yet been compared, and the verdict is recorded in that buffer slot. Verified slots leave from the head of the buffer through a ready/valid write port. A slot that failed the comparison is dropped without a write, and the block raises a sticky fault flag. A trailing store that arrives with no leading store waiting for it is treated as a protocol error and also raises the fault. A full buffer holds back the leading thread only. The trailing thread can always commit, so the pair cannot deadlock on its own buffer.

Top module: `dualStoreVerifier`

## Requirements
- R1: After reset `memValid` is 0, `fault` is 0, `bufFull` is 0 and `leadReady` is 1.
- R2: A leading store accepted on a rising edge (`leadValid` with `leadReady` high) is held in the buffer. It never raises `memValid` while no trailing store has been compared with it.
- R3: A trailing store whose address and data both equal those of the oldest uncompared leading store marks that store verified. When that store is at the buffer head, `memValid` is 1 in the cycle after the trailing store's edge, carrying the leading store's address and data.
- R4: Pairing is in program order. The n-th trailing store since reset is compared with the n-th accepted leading store, and verified stores leave on the write port in the order the leading thread committed them.
- R5: A trailing store that differs from its paired leading store in address, in data, or in both sets `fault` to 1 one cycle later. `fault` stays 1 until reset. The paired leading store is discarded without ever asserting `memValid`, and later stores that verify are still written.
- R6: A trailing store that arrives while no leading store is waiting for comparison sets `fault` to 1 one cycle later.
- R7: When DEPTH stores (default 16) are buffered, `bufFull` is 1 and `leadReady` is 0. A leading store offered in that state is not stored, and a trailing store offered in that state is still compared.
- R8: While `memValid` is 1 and `memReady` is 0, `memValid`, `memAddr` and `memData` hold their values. The head store leaves the buffer on the edge where `memValid` and `memReady` are both 1, and its slot becomes free for a leading store from the next cycle on.
- R9: Trailing stores are compared and recorded even while the head store is stalled on the write port. They are then written, in order, once `memReady` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| leadValid | input | 1 | Leading thread commits a store this cycle |
| leadAddr | input | AW | Leading store address |
| leadData | input | DW | Leading store data |
| leadReady | output | 1 | Buffer can take a leading store (not full) |
| trailValid | input | 1 | Trailing thread commits a store this cycle (never stalled) |
| trailAddr | input | AW | Trailing store address |
| trailData | input | DW | Trailing store data |
| memValid | output | 1 | Verified store offered to memory |
| memAddr | output | AW | Address of the offered store |
| memData | output | DW | Data of the offered store |
| memReady | input | 1 | Memory accepts the offered store |
| bufFull | output | 1 | Buffer holds DEPTH stores |
| fault | output | 1 | Sticky flag: store mismatch or unpaired trailing store |

## Verification
A store accepted on an edge is visible in buffer status right after that edge. A matching trailing store turns a waiting head store into a write offer one cycle after the edge that took it, and a mismatch or an unpaired trailing store shows on `fault` at the same point. A handshake frees its slot, and moves the next verified store onto the port, from the following cycle on. The bench drives every input at the falling edge and advances its own buffer model at that moment, as the design will at the coming rising edge. It then compares all outputs at the next falling edge, so each result is sampled exactly one register stage after its cause.

// File: rtl/storeCmpPkg.sv
package storeCmpPkg;

  // Verdict kept per buffer slot.
  typedef enum logic [1:0] {
    SLOT_PEND = 2'd0,  // waiting for its trailing copy
    SLOT_GOOD = 2'd1,  // trailing copy matched, may be written
    SLOT_BAD  = 2'd2   // trailing copy differed, to be dropped
  } slotState_e;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic push;      // write leading store into tail slot
    logic markGood;  // record a match in the compare slot
    logic markBad;   // record a mismatch in the compare slot
    logic pop;       // release the head slot
  } ctlStrobes_t;

endpackage

// File: rtl/storeCmpData.sv
module storeCmpData
  import storeCmpPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strb,
  input  logic [PTR_W-1:0] tailIdx,
  input  logic [PTR_W-1:0] vfyIdx,
  input  logic [PTR_W-1:0] headIdx,
  input  logic [AW-1:0]    leadAddr,
  input  logic [DW-1:0]    leadData,
  input  logic [AW-1:0]    trailAddr,
  input  logic [DW-1:0]    trailData,
  output slotState_e       headState,
  output logic [AW-1:0]    headAddr,
  output logic [DW-1:0]    headData,
  output logic             trailMatch
);

  logic [AW-1:0] addrVec  [DEPTH];
  logic [DW-1:0] dataVec  [DEPTH];
  slotState_e    stateVec [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : gSlot
    logic [AW-1:0] slotAddr;
    logic [DW-1:0] slotData;
    slotState_e    slotSt;
    logic          hitTail;
    logic          hitVfy;

    assign hitTail = strb.push && (tailIdx == PTR_W'(s));
    assign hitVfy  = vfyIdx == PTR_W'(s);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotAddr <= '0;
        slotData <= '0;
      end else if (hitTail) begin
        slotAddr <= leadAddr;
        slotData <= leadData;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotSt <= SLOT_PEND;
      end else if (hitTail) begin
        slotSt <= SLOT_PEND;
      end else if (strb.markGood && hitVfy) begin
        slotSt <= SLOT_GOOD;
      end else if (strb.markBad && hitVfy) begin
        slotSt <= SLOT_BAD;
      end
    end

    assign addrVec[s]  = slotAddr;
    assign dataVec[s]  = slotData;
    assign stateVec[s] = slotSt;
  end

  assign headState  = stateVec[headIdx];
  assign headAddr   = addrVec[headIdx];
  assign headData   = dataVec[headIdx];
  assign trailMatch = (addrVec[vfyIdx] == trailAddr) && (dataVec[vfyIdx] == trailData);

  // A verdict is only ever written into a slot still waiting for one (R4).
  assert_mark_pending_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.markGood || strb.markBad) |-> (stateVec[vfyIdx] == SLOT_PEND));

  // Only a slot with a verdict ever leaves the buffer (R2).
  assert_pop_decided_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> (stateVec[headIdx] != SLOT_PEND));

  // A freshly pushed slot starts out undecided (R2).
  assert_push_pending_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> (stateVec[$past(tailIdx)] == SLOT_PEND));

endmodule

// File: rtl/storeCmpCtrl.sv
module storeCmpCtrl
  import storeCmpPkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             leadValid,
  input  logic             trailValid,
  input  logic             trailMatch,
  input  slotState_e       headState,
  input  logic             memReady,
  output ctlStrobes_t      strb,
  output logic [PTR_W-1:0] tailIdx,
  output logic [PTR_W-1:0] vfyIdx,
  output logic [PTR_W-1:0] headIdx,
  output logic             leadReady,
  output logic             bufFull,
  output logic             memValid,
  output logic             fault
);

  logic [CNT_W-1:0] usedCnt;  // slots holding a store
  logic [CNT_W-1:0] pendCnt;  // slots still waiting for a trailing copy
  logic             haveHead;
  logic             trailHit;
  logic             orphanTrail;

  function automatic logic [PTR_W-1:0] bumpIdx(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign bufFull     = usedCnt == CNT_W'(DEPTH);
  assign leadReady   = !bufFull;
  assign haveHead    = usedCnt != '0;
  assign memValid    = haveHead && (headState == SLOT_GOOD);
  assign trailHit    = trailValid && (pendCnt != '0);
  assign orphanTrail = trailValid && (pendCnt == '0);

  always_comb begin
    strb          = '0;
    strb.push     = leadValid && !bufFull;
    strb.markGood = trailHit && trailMatch;
    strb.markBad  = trailHit && !trailMatch;
    strb.pop      = haveHead && ((headState == SLOT_GOOD && memReady) || headState == SLOT_BAD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tailIdx <= '0;
      vfyIdx  <= '0;
      headIdx <= '0;
      usedCnt <= '0;
      pendCnt <= '0;
    end else begin
      if (strb.push) tailIdx <= bumpIdx(tailIdx);
      if (trailHit)  vfyIdx  <= bumpIdx(vfyIdx);
      if (strb.pop)  headIdx <= bumpIdx(headIdx);
      usedCnt <= usedCnt + CNT_W'(strb.push) - CNT_W'(strb.pop);
      pendCnt <= pendCnt + CNT_W'(strb.push) - CNT_W'(trailHit);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fault <= 1'b0;
    end else if (strb.markBad || orphanTrail) begin
      fault <= 1'b1;
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    usedCnt <= CNT_W'(DEPTH));

  assert_full_blocks_lead_R7: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && leadValid) |=> (usedCnt <= $past(usedCnt)));

  assert_pend_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= usedCnt);

  assert_offer_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> memValid);

  assert_fault_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> fault);

  assert_mismatch_faults_R5: assert property (@(posedge clk) disable iff (!rstN)
    (trailValid && pendCnt != '0 && !trailMatch) |=> fault);

  assert_orphan_faults_R6: assert property (@(posedge clk) disable iff (!rstN)
    (trailValid && pendCnt == '0) |=> fault);

  assert_trail_consumed_R9: assert property (@(posedge clk) disable iff (!rstN)
    (trailValid && pendCnt != '0) |=> ((pendCnt != $past(pendCnt)) || $past(strb.push)));

endmodule

// File: rtl/dualStoreVerifier.sv
module dualStoreVerifier
  import storeCmpPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          leadValid,
  input  logic [AW-1:0] leadAddr,
  input  logic [DW-1:0] leadData,
  output logic          leadReady,
  input  logic          trailValid,
  input  logic [AW-1:0] trailAddr,
  input  logic [DW-1:0] trailData,
  output logic          memValid,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memData,
  input  logic          memReady,
  output logic          bufFull,
  output logic          fault
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ctlStrobes_t      strb;
  logic [PTR_W-1:0] tailIdx;
  logic [PTR_W-1:0] vfyIdx;
  logic [PTR_W-1:0] headIdx;
  slotState_e       headState;
  logic             trailMatch;

  storeCmpCtrl #(.DEPTH(DEPTH)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .leadValid  (leadValid),
    .trailValid (trailValid),
    .trailMatch (trailMatch),
    .headState  (headState),
    .memReady   (memReady),
    .strb       (strb),
    .tailIdx    (tailIdx),
    .vfyIdx     (vfyIdx),
    .headIdx    (headIdx),
    .leadReady  (leadReady),
    .bufFull    (bufFull),
    .memValid   (memValid),
    .fault      (fault)
  );

  storeCmpData #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .tailIdx    (tailIdx),
    .vfyIdx     (vfyIdx),
    .headIdx    (headIdx),
    .leadAddr   (leadAddr),
    .leadData   (leadData),
    .trailAddr  (trailAddr),
    .trailData  (trailData),
    .headState  (headState),
    .headAddr   (memAddr),
    .headData   (memData),
    .trailMatch (trailMatch)
  );

  // The offered store must not change while memory stalls it (R8).
  assert_offer_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> ($stable(memAddr) && $stable(memData)));

endmodule

// File: tb/sim_dualStoreVerifier.sv
`timescale 1ns/1ps
module sim_dualStoreVerifier;

  localparam int DEPTH = 16;
  localparam int AW    = 32;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          leadValid = 1'b0;
  logic [AW-1:0] leadAddr = '0;
  logic [DW-1:0] leadData = '0;
  logic          leadReady;
  logic          trailValid = 1'b0;
  logic [AW-1:0] trailAddr = '0;
  logic [DW-1:0] trailData = '0;
  logic          memValid;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memData;
  logic          memReady = 1'b0;
  logic          bufFull;
  logic          fault;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  dualStoreVerifier #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rstN(rstN),
    .leadValid(leadValid), .leadAddr(leadAddr), .leadData(leadData), .leadReady(leadReady),
    .trailValid(trailValid), .trailAddr(trailAddr), .trailData(trailData),
    .memValid(memValid), .memAddr(memAddr), .memData(memData), .memReady(memReady),
    .bufFull(bufFull), .fault(fault)
  );

  // Expected buffer: state 0 waiting, 1 verified, 2 rejected.
  logic [AW-1:0] qA[$];
  logic [DW-1:0] qD[$];
  int            qS[$];
  int            mPend = 0;
  bit            mFault = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit expValid();
    return (qS.size() > 0) && (qS[0] == 1);
  endfunction

  task automatic compareAll(input string tag);
    bit full;
    full = qS.size() == DEPTH;
    chk(memValid == expValid(), tag, "memValid", 64'(memValid), 64'(expValid()));
    if (expValid()) begin
      chk(memAddr == qA[0], tag, "memAddr", 64'(memAddr), 64'(qA[0]));
      chk(memData == qD[0], tag, "memData", 64'(memData), 64'(qD[0]));
    end
    chk(bufFull == full, tag, "bufFull", 64'(bufFull), 64'(full));
    chk(leadReady == !full, tag, "leadReady", 64'(leadReady), 64'(!full));
    chk(fault == mFault, tag, "fault", 64'(fault), 64'(mFault));
  endtask

  // Advance the expected buffer the way the next rising edge must.
  task automatic modelStep(input bit lv, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                           input bit tv, input logic [AW-1:0] ta, input logic [DW-1:0] td,
                           input bit mr);
    int  used;
    bit  doPop;
    used  = qS.size();
    doPop = (used > 0) && ((qS[0] == 1 && mr) || qS[0] == 2);
    if (tv) begin
      if (mPend == 0) begin
        mFault = 1'b1;
      end else begin
        int idx;
        idx = used - mPend;
        if (qA[idx] == ta && qD[idx] == td) qS[idx] = 1;
        else begin
          qS[idx] = 2;
          mFault = 1'b1;
        end
        mPend--;
      end
    end
    if (doPop) begin
      void'(qA.pop_front());
      void'(qD.pop_front());
      void'(qS.pop_front());
    end
    if (lv && used < DEPTH) begin
      qA.push_back(la);
      qD.push_back(ld);
      qS.push_back(0);
      mPend++;
    end
  endtask

  task automatic stepCyc(input bit lv, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                         input bit tv, input logic [AW-1:0] ta, input logic [DW-1:0] td,
                         input bit mr, input string tag);
    leadValid = lv; leadAddr = la; leadData = ld;
    trailValid = tv; trailAddr = ta; trailData = td;
    memReady = mr;
    modelStep(lv, la, ld, tv, ta, td, mr);
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic idle(input bit mr, input int n, input string tag);
    for (int i = 0; i < n; i++) stepCyc(0, '0, '0, 0, '0, '0, mr, tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    leadValid = 0; trailValid = 0; memReady = 0;
    qA.delete(); qD.delete(); qS.delete();
    mPend = 0; mFault = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    compareAll("R1");
  endtask

  initial begin : watchdog
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : mainSeq
    int unsigned seedSink;
    seedSink = $urandom(32'd20240);
    @(negedge clk);
    compareAll("R1");
    doReset();

    // R2: leading store alone never reaches memory
    stepCyc(1, 32'h100, 32'hA0, 0, '0, '0, 1, "R2");
    idle(1, 3, "R2");

    // R3 + R8: match, then stall, then handshake
    stepCyc(0, '0, '0, 1, 32'h100, 32'hA0, 0, "R3");
    idle(0, 2, "R8");
    idle(1, 2, "R8");

    // R4: two stores paired in program order
    stepCyc(1, 32'h200, 32'hB0, 0, '0, '0, 1, "R4");
    stepCyc(1, 32'h204, 32'hB4, 0, '0, '0, 1, "R4");
    stepCyc(0, '0, '0, 1, 32'h200, 32'hB0, 0, "R4");
    stepCyc(0, '0, '0, 1, 32'h204, 32'hB4, 0, "R4");
    idle(1, 3, "R4");

    // R9: trailing stores verified while the write port is stalled
    stepCyc(1, 32'h300, 32'hC0, 0, '0, '0, 0, "R9");
    stepCyc(1, 32'h304, 32'hC4, 0, '0, '0, 0, "R9");
    stepCyc(0, '0, '0, 1, 32'h300, 32'hC0, 0, "R9");
    stepCyc(0, '0, '0, 1, 32'h304, 32'hC4, 0, "R9");
    idle(0, 2, "R9");
    idle(1, 3, "R9");

    // R5: data mismatch drops the store, fault sticks, later stores still flow
    stepCyc(1, 32'h400, 32'hD0, 0, '0, '0, 1, "R5");
    stepCyc(0, '0, '0, 1, 32'h400, 32'hD1, 1, "R5");
    idle(1, 2, "R5");
    stepCyc(1, 32'h404, 32'hD4, 0, '0, '0, 1, "R5");
    stepCyc(0, '0, '0, 1, 32'h404, 32'hD4, 0, "R5");
    idle(1, 2, "R5");
    // R5: address mismatch after reset
    doReset();
    stepCyc(1, 32'h410, 32'hE0, 0, '0, '0, 1, "R5");
    stepCyc(0, '0, '0, 1, 32'h418, 32'hE0, 1, "R5");
    idle(1, 3, "R5");

    // R6: unpaired trailing store
    doReset();
    stepCyc(0, '0, '0, 1, 32'h500, 32'hF0, 1, "R6");
    idle(1, 2, "R6");

    // R7: fill the buffer, extra leading store refused, trailing still taken
    doReset();
    for (int i = 0; i < DEPTH; i++)
      stepCyc(1, 32'h600 + 32'(i * 4), 32'h1000 + 32'(i), 0, '0, '0, 0, "R7");
    stepCyc(1, 32'h6FC, 32'hDEAD, 0, '0, '0, 0, "R7");
    stepCyc(0, '0, '0, 1, 32'h600, 32'h1000, 0, "R7");
    for (int i = 1; i < DEPTH; i++)
      stepCyc(0, '0, '0, 1, 32'h600 + 32'(i * 4), 32'h1000 + 32'(i), 1, "R7");
    idle(1, 3, "R7");
    // refused store must not be waiting: a further trailing store is unpaired
    stepCyc(0, '0, '0, 1, 32'h6FC, 32'hDEAD, 1, "R7");
    idle(1, 1, "R7");

    // Random traffic, checked against the expected buffer
    for (int round = 0; round < 4; round++) begin
      doReset();
      for (int n = 0; n < 700; n++) begin
        bit            lv, tv, mr;
        logic [AW-1:0] la, ta;
        logic [DW-1:0] ld, td;
        lv = ($urandom % 3) != 0;
        la = {$urandom % 64, 2'b00};
        ld = $urandom;
        mr = ($urandom % 4) != 0;
        tv = 0; ta = '0; td = '0;
        if (mPend > 0 && ($urandom % 2) == 1) begin
          int idx;
          idx = qS.size() - mPend;
          tv = 1; ta = qA[idx]; td = qD[idx];
          if ($urandom % 80 == 0) td = td ^ (DW'(1) << ($urandom % DW));
        end else if (mPend == 0 && $urandom % 200 == 0) begin
          tv = 1; ta = la; td = ld;
        end
        stepCyc(lv, la, ld, tv, ta, td, mr, "R3");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule